// File: doc/BRIEF.md
# PCI address phase decoder

This block sits beside a 32-bit PCI bus and watches the sampled FRAME#, IRDY#, AD and C/BE# lines for the start of each transaction. It captures the address and the bus command from the address phase or phases and builds a 64-bit address. A 32-bit access uses one address phase. A 64-bit access uses two: the low half arrives with the dual-address command, and the high half arrives with the real command on the next clock.

The assembled address is compared against a 64-bit prefetchable memory window given by a base and a limit input. Claiming is strictly positive: a transaction is claimed for downstream forwarding only when it is a memory command and its address lies inside the window. The block also reports whether the address allows a linear incrementing burst. If it does not, the transfer must be disconnected after its first data phase.

Top module: `pci_addr_decode`

## Requirements
- R1: While reset is held and right after it, `claim`, `dual`, `lin_burst`, `cmd` and `addr` are all zero.
- R2: After reset, FRAME# is ignored until one clock samples FRAME# and IRDY# both deasserted (high). A FRAME# held low from reset onward starts no decode.
- R3: A transaction starts on the first clock where FRAME# is sampled low while the bus is idle. If C/BE# is not 4'b1101, that clock is the only address phase. The outputs then become `addr` = {32'h0, AD}, `cmd` = the C/BE# value and `dual` = 0, visible one clock later.
- R4: If C/BE# equals 4'b1101 in the first phase, the next clock is a second address phase. The outputs then become `addr` = {AD of phase 2, AD of phase 1}, `cmd` = the C/BE# of phase 2 and `dual` = 1, visible one clock after phase 2.
- R5: A claim needs win_base <= addr <= win_limit, compared as 64-bit unsigned values with both ends included. When win_base > win_limit, nothing is claimed.
- R6: Only memory commands are claimed: C/BE# values 4'b0110, 4'b0111, 4'b1100, 4'b1110 and 4'b1111. All other commands are never claimed, whatever the address.
- R7: `claim` is a one-cycle pulse in the cycle after the final address phase. `addr`, `cmd`, `dual` and `lin_burst` hold their values until the next decode.
- R8: `lin_burst` is 1 exactly when addr[1:0] is 2'b00. Any other value gives 0, which requests a disconnect after the first data transfer.
- R9: Once a transaction has started, further FRAME# assertions are ignored until FRAME# and IRDY# have both been sampled high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_n | input | 1 | Sampled FRAME#, active low |
| irdy_n | input | 1 | Sampled IRDY#, active low |
| ad | input | 32 | Sampled address/data lines |
| cbe_n | input | 4 | Sampled command/byte-enable lines |
| win_base | input | 64 | Lowest address of the prefetchable window |
| win_limit | input | 64 | Highest address of the prefetchable window |
| claim | output | 1 | One-cycle pulse: transaction claimed for downstream |
| addr | output | 64 | Captured 64-bit address |
| cmd | output | 4 | Captured real bus command |
| dual | output | 1 | Last decode used two address phases |
| lin_burst | output | 1 | Address permits a linear incrementing burst |

## Verification
The phase tracker can hold a wrong state, for example missing the return to idle or taking a data phase for an address phase. Either fault shows up at the ports on the clock after the stray FRAME# edge: `addr` or `cmd` changes in the middle of a transaction, or `claim` pulses when it should not. A lost low half, or a mistaken dual-phase detection, shows as a wrong upper or lower address word or a wrong `dual` value in the same cycle as the claim. Window edges one below the base and one above the limit, an empty window, non-memory commands, and FRAME# held low through reset each expose a specific fault within one or two clocks.

// File: rtl/pad_pkg.sv
package pad_pkg;
  localparam int CBW = 4;
  localparam logic [CBW-1:0] CMD_DAC = 4'b1101;

  typedef enum logic [1:0] {
    PH_WAIT = 2'd0,
    PH_IDLE = 2'd1,
    PH_HI   = 2'd2,
    PH_BUSY = 2'd3
  } ph_e;

  function automatic logic is_mem_cmd(input logic [CBW-1:0] c);
    logic r;
    case (c)
      4'b0110, 4'b0111, 4'b1100, 4'b1110, 4'b1111: r = 1'b1;
      default: r = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/pad_rst_sync.sv
module pad_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/pad_phase_fsm.sv
module pad_phase_fsm
  import pad_pkg::*;
(
  input  logic           clk,
  input  logic           rst_sn,
  input  logic           frame_n,
  input  logic           irdy_n,
  input  logic [CBW-1:0] cbe_n,
  output logic           lo_cap,
  output logic           dec_done,
  output logic           dec_dual
);
  ph_e  st_q, st_d;
  logic bus_idle, start, is_dac;

  assign bus_idle = frame_n & irdy_n;
  assign start    = (st_q == PH_IDLE) & ~frame_n;
  assign is_dac   = (cbe_n == CMD_DAC);

  always_comb begin
    st_d = st_q;
    case (st_q)
      PH_WAIT: if (bus_idle) st_d = PH_IDLE;
      PH_IDLE: if (!frame_n) st_d = is_dac ? PH_HI : PH_BUSY;
      PH_HI:   st_d = PH_BUSY;
      PH_BUSY: if (bus_idle) st_d = PH_IDLE;
      default: st_d = PH_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) st_q <= PH_WAIT;
    else         st_q <= st_d;
  end

  assign lo_cap   = start;
  assign dec_dual = (st_q == PH_HI);
  assign dec_done = (start & ~is_dac) | dec_dual;

  AST_WAIT_IGNORES_FRAME: assert property (@(posedge clk) disable iff (!rst_sn)
    (st_q == PH_WAIT && !bus_idle) |=> !lo_cap); // R2
  AST_HI_AFTER_DAC: assert property (@(posedge clk) disable iff (!rst_sn)
    dec_dual |-> $past(lo_cap && is_dac)); // R4
  AST_BUSY_IGNORES_FRAME: assert property (@(posedge clk) disable iff (!rst_sn)
    (st_q == PH_BUSY && !bus_idle) |=> !lo_cap); // R9
endmodule

// File: rtl/pad_capture.sv
module pad_capture
  import pad_pkg::*;
#(
  parameter int ADW = 32,
  localparam int AW = 2 * ADW
) (
  input  logic           clk,
  input  logic           rst_sn,
  input  logic           lo_cap,
  input  logic           dec_done,
  input  logic           dec_dual,
  input  logic [ADW-1:0] ad,
  input  logic [CBW-1:0] cbe_n,
  output logic [AW-1:0]  nxt_addr,
  output logic [AW-1:0]  addr_q,
  output logic [CBW-1:0] cmd_q,
  output logic           dual_q,
  output logic           lin_q
);
  logic [ADW-1:0] lo_q, lo_d;
  logic [AW-1:0]  addr_d;
  logic [CBW-1:0] cmd_d;
  logic           dual_d, lin_d;

  always_comb begin
    lo_d = lo_q;
    if (lo_cap) lo_d = ad;
    nxt_addr = dec_dual ? {ad, lo_q} : {{ADW{1'b0}}, ad};
    addr_d = addr_q;
    cmd_d  = cmd_q;
    dual_d = dual_q;
    lin_d  = lin_q;
    if (dec_done) begin
      addr_d = nxt_addr;
      cmd_d  = cbe_n;
      dual_d = dec_dual;
      lin_d  = (nxt_addr[1:0] == 2'b00);
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      lo_q   <= '0;
      addr_q <= '0;
      cmd_q  <= '0;
      dual_q <= 1'b0;
      lin_q  <= 1'b0;
    end else begin
      lo_q   <= lo_d;
      addr_q <= addr_d;
      cmd_q  <= cmd_d;
      dual_q <= dual_d;
      lin_q  <= lin_d;
    end
  end

  AST_OUTPUTS_HOLD: assert property (@(posedge clk) disable iff (!rst_sn)
    !dec_done |=> ($stable(addr_q) && $stable(cmd_q) && $stable(dual_q))); // R7
  AST_DUAL_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_sn)
    (dec_done && dec_dual) |=> (addr_q[ADW-1:0] == $past(lo_q))); // R4
endmodule

// File: rtl/pad_window_cmp.sv
module pad_window_cmp #(
  parameter int AW = 64
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] limit,
  output logic          hit
);
  logic win_on, above_base, below_limit;

  always_comb begin
    win_on      = (base <= limit);
    above_base  = (addr >= base);
    below_limit = (addr <= limit);
    hit         = win_on & above_base & below_limit;
  end
endmodule

// File: rtl/pci_addr_decode.sv
module pci_addr_decode
  import pad_pkg::*;
#(
  parameter int ADW = 32,
  localparam int AW = 2 * ADW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           frame_n,
  input  logic           irdy_n,
  input  logic [ADW-1:0] ad,
  input  logic [CBW-1:0] cbe_n,
  input  logic [AW-1:0]  win_base,
  input  logic [AW-1:0]  win_limit,
  output logic           claim,
  output logic [AW-1:0]  addr,
  output logic [CBW-1:0] cmd,
  output logic           dual,
  output logic           lin_burst
);
  logic          rst_sn;
  logic          lo_cap, dec_done, dec_dual;
  logic [AW-1:0] nxt_addr;
  logic          hit, claim_d, claim_q;

  pad_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn)
  );

  pad_phase_fsm u_fsm (
    .clk(clk), .rst_sn(rst_sn), .frame_n(frame_n), .irdy_n(irdy_n),
    .cbe_n(cbe_n), .lo_cap(lo_cap), .dec_done(dec_done), .dec_dual(dec_dual)
  );

  pad_capture #(.ADW(ADW)) u_cap (
    .clk(clk), .rst_sn(rst_sn), .lo_cap(lo_cap), .dec_done(dec_done),
    .dec_dual(dec_dual), .ad(ad), .cbe_n(cbe_n), .nxt_addr(nxt_addr),
    .addr_q(addr), .cmd_q(cmd), .dual_q(dual), .lin_q(lin_burst)
  );

  pad_window_cmp #(.AW(AW)) u_win (
    .addr(nxt_addr), .base(win_base), .limit(win_limit), .hit(hit)
  );

  always_comb claim_d = dec_done & hit & is_mem_cmd(cbe_n);

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) claim_q <= 1'b0;
    else         claim_q <= claim_d;
  end

  assign claim = claim_q;

  AST_CLAIM_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_sn)
    claim |=> !claim); // R7
  AST_CLAIM_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_sn)
    claim |-> (addr >= $past(win_base) && addr <= $past(win_limit))); // R5
  AST_CLAIM_MEMORY_ONLY: assert property (@(posedge clk) disable iff (!rst_sn)
    claim |-> is_mem_cmd(cmd)); // R6
  AST_SINGLE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_sn)
    (claim && !dual) |-> (addr[AW-1:ADW] == '0)); // R3
  AST_LIN_MATCHES_ADDR: assert property (@(posedge clk) disable iff (!rst_sn)
    claim |-> (lin_burst == (addr[1:0] == 2'b00))); // R8
endmodule

// File: tb/sim_pci_addr_decode.sv
module sim_pci_addr_decode;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_n, irdy_n;
  logic [31:0] ad;
  logic [3:0]  cbe_n;
  logic [63:0] win_base, win_limit;
  logic        claim, dual, lin_burst;
  logic [63:0] addr;
  logic [3:0]  cmd;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  pci_addr_decode u0 (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .ad(ad),
    .cbe_n(cbe_n), .win_base(win_base), .win_limit(win_limit), .claim(claim),
    .addr(addr), .cmd(cmd), .dual(dual), .lin_burst(lin_burst)
  );

  function automatic bit mem_cmd(input logic [3:0] c);
    return (c == 4'b0110) || (c == 4'b0111) || (c == 4'b1100) ||
           (c == 4'b1110) || (c == 4'b1111);
  endfunction

  function automatic bit want_claim(input logic [63:0] a, input logic [3:0] c,
                                    input logic [63:0] b, input logic [63:0] l);
    return (b <= l) && (a >= b) && (a <= l) && mem_cmd(c);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_txn(input bit is_dual, input logic [31:0] lo,
                        input logic [31:0] hi, input logic [3:0] c);
    logic [63:0] ea;
    bit          ec;
    ea = is_dual ? {hi, lo} : {32'h0, lo};
    ec = want_claim(ea, c, win_base, win_limit);
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; ad = lo; cbe_n = is_dual ? 4'b1101 : c;
    if (is_dual) begin
      @(negedge clk);
      ad = hi; cbe_n = c;
    end
    @(negedge clk);
    chk(claim == ec, "R5/R6 claim", {63'h0, claim}, {63'h0, ec});
    chk(addr == ea, is_dual ? "R4 addr" : "R3 addr", addr, ea);
    chk(cmd == c, is_dual ? "R4 cmd" : "R3 cmd", {60'h0, cmd}, {60'h0, c});
    chk(dual == is_dual, "R3/R4 dual", {63'h0, dual}, {63'h0, is_dual});
    chk(lin_burst == (lo[1:0] == 2'b00), "R8 lin_burst", {63'h0, lin_burst},
        {63'h0, (lo[1:0] == 2'b00)});
    frame_n = 1'b0; irdy_n = 1'b0; ad = $urandom(); cbe_n = 4'b0000;
    @(negedge clk);
    chk(claim == 1'b0, "R7 claim pulse width", {63'h0, claim}, 64'h0);
    frame_n = 1'b1; irdy_n = 1'b0;
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b0; ad = win_base[31:0]; cbe_n = 4'b0111;
    @(negedge clk);
    frame_n = 1'b1; irdy_n = 1'b0;
    @(negedge clk);
    chk(claim == 1'b0, "R9 no restart mid-transaction", {63'h0, claim}, 64'h0);
    chk(addr == ea, "R9 addr held", addr, ea);
    chk(cmd == c, "R7 cmd held", {60'h0, cmd}, {60'h0, c});
    frame_n = 1'b1; irdy_n = 1'b1; ad = '0; cbe_n = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20241));
    rst_n = 1'b0; frame_n = 1'b1; irdy_n = 1'b1; ad = '0; cbe_n = '0;
    win_base = 64'h0; win_limit = 64'hFFFF_FFFF_FFFF_FFFF;
    repeat (4) @(negedge clk);
    chk(claim == 1'b0 && addr == 64'h0 && cmd == 4'h0 && dual == 1'b0 &&
        lin_burst == 1'b0, "R1 reset outputs", addr, 64'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(claim == 1'b0 && addr == 64'h0, "R1 after release", addr, 64'h0);

    // R2: FRAME# held low through reset is not a start
    rst_n = 1'b0;
    frame_n = 1'b0; irdy_n = 1'b0; ad = 32'h0000_1000; cbe_n = 4'b0111;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(claim == 1'b0 && addr == 64'h0, "R2 frame ignored before idle",
          addr, 64'h0);
    end
    frame_n = 1'b1; irdy_n = 1'b1;
    @(negedge clk);
    frame_n = 1'b1;
    do_txn(1'b0, 32'h0000_1000, 32'h0, 4'b0111);

    // Directed window edges across the 32-bit boundary
    win_base  = 64'h0000_0001_FFFF_FFF0;
    win_limit = 64'h0000_0002_0000_00FF;
    do_txn(1'b1, 32'hFFFF_FFF0, 32'h1, 4'b0110);   // R5 equal to base
    do_txn(1'b1, 32'hFFFF_FFEF, 32'h1, 4'b0110);   // R5 one below base
    do_txn(1'b1, 32'h0000_00FF, 32'h2, 4'b1111);   // R5 equal to limit
    do_txn(1'b1, 32'h0000_0100, 32'h2, 4'b1111);   // R5 one above limit
    do_txn(1'b1, 32'h0000_0011, 32'h2, 4'b1110);   // R8 non-linear order
    do_txn(1'b1, 32'h0000_0010, 32'h2, 4'b0011);   // R6 I/O command in window
    do_txn(1'b0, 32'h0000_0010, 32'h0, 4'b0111);   // R3 single, outside window
    // R5 empty window
    win_base  = 64'h0000_0000_0000_2000;
    win_limit = 64'h0000_0000_0000_1FFF;
    do_txn(1'b0, 32'h0000_2000, 32'h0, 4'b0111);
    // R6 config command inside a full window
    win_base  = 64'h0;
    win_limit = 64'hFFFF_FFFF_FFFF_FFFF;
    do_txn(1'b0, 32'h0000_0800, 32'h0, 4'b1010);
    do_txn(1'b0, 32'h0000_0802, 32'h0, 4'b1100);   // R8 with single phase

    // Random mix
    for (int n = 0; n < 300; n++) begin
      logic [63:0] b, l, a;
      logic [3:0]  c;
      bit          dl;
      b = {32'($urandom % 4), 32'($urandom())};
      l = b + {32'($urandom % 2), 32'($urandom())};
      if (($urandom % 8) == 0) begin
        a = b; b = l; l = a;
      end
      case ($urandom % 4)
        0: a = b + 64'($urandom % 4) - 64'd2;
        1: a = l + 64'($urandom % 4) - 64'd2;
        2: a = b + {32'($urandom % 2), 32'($urandom())};
        default: a = {32'($urandom % 5), 32'($urandom())};
      endcase
      dl = (a[63:32] != 32'h0) || (($urandom % 4) == 0);
      if (!dl) a[63:32] = 32'h0;
      c = 4'($urandom % 16);
      if (!dl && c == 4'b1101) c = 4'b0111;
      if (($urandom % 3) == 0) c = 4'b0110;
      win_base = b; win_limit = l;
      do_txn(dl, a[31:0], a[63:32], c);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule